// File: doc/BRIEF.md
# Runahead Mode Entry Controller

This controller sits beside an out-of-order core and decides when the core should stop stalling behind a long-latency miss and run ahead speculatively instead. It watches miss allocation and completion events and tracks each outstanding miss, together with an age timer, in a small table. When the oldest instruction in the window is stalled on one of those misses, the controller takes the runahead mode only if three gates pass. The miss must be young enough that it will not return almost at once. Enough instructions must have been fetched since the last period that the new one will not repeat work already done. The load must not carry a "never run ahead" hint.

On entry it pulses a checkpoint request for the architectural registers, the branch history and the return stack. It leaves runahead mode when the miss that caused the period completes, or earlier when too large a share of the loads seen in the period are invalid (miss-dependent). On exit it pulses flush and restore requests for one cycle. Every input is an event strobe or a level that is always accepted. There is no back-pressure at any pin, and a strobe counts in the cycle it is high.

Top module: `rh_entry_ctrl`

## Requirements
- R1: After reset `ra_active`, `ckpt_req`, `flush_req` and `restore_req` are all 0.
- R2: In normal mode, a cycle with `stall_vld` high whose `stall_tag` matches an outstanding miss and which passes the gates of R4 to R6 causes entry. In the following cycle `ra_active` is 1 and `ckpt_req` is 1 for exactly that one cycle. A stall held while already in runahead mode raises no further checkpoint request.
- R3: A stall on a tag that has no outstanding miss in the table never causes entry.
- R4: Each outstanding miss has a saturating cycle timer that starts at 0 on allocation. Entry is suppressed when that timer is greater than `age_thresh`.
- R5: The controller counts `pretire_vld` strobes during a period and latches the total at exit. It counts `fetch_vld` strobes in normal mode from 0 after each exit. Entry is suppressed while the fetched count is less than the latched count. Both counters saturate.
- R6: A stall with `stall_no_ra` high never causes entry.
- R7: The completion (`miss_done_vld` with `miss_done_tag`) of the miss that caused the period ends it. In the next cycle `ra_active` is 0 and `flush_req` and `restore_req` are both 1 for one cycle. Completions of other tags leave the mode unchanged.
- R8: During a period the controller counts load strobes and invalid load strobes. Once at least 4 loads have been seen and invalid*16 > `inv_thresh`*loads, it exits with the flush and restore pulses of R7. A value of 16 for `inv_thresh` disables the early exit.
- R9: The table holds 8 misses. A completion and an allocation in the same cycle are both applied, and the completion frees its entry first, so a full table still takes the new miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_alloc_vld | input | 1 | A new long-latency miss has been issued |
| miss_alloc_tag | input | 6 | Tag of the new miss |
| miss_done_vld | input | 1 | An outstanding miss has completed |
| miss_done_tag | input | 6 | Tag of the completed miss |
| stall_vld | input | 1 | Oldest instruction is waiting on a miss |
| stall_tag | input | 6 | Tag of the miss the oldest instruction waits on |
| stall_no_ra | input | 1 | Stalled load is hinted never to start runahead |
| pretire_vld | input | 1 | One instruction pseudo-retired in runahead mode |
| fetch_vld | input | 1 | One instruction fetched |
| load_vld | input | 1 | A load was executed in runahead mode |
| load_inv | input | 1 | That load's result is invalid |
| age_thresh | input | 10 | Maximum miss age, in cycles, that still allows entry |
| inv_thresh | input | 5 | Invalid-load share limit, in sixteenths |
| ra_active | output | 1 | Runahead mode is active |
| ckpt_req | output | 1 | One-cycle checkpoint request on entry |
| flush_req | output | 1 | One-cycle pipeline flush request on exit |
| restore_req | output | 1 | One-cycle checkpoint restore request on exit |

## Verification
The function that can collide with itself in one cycle is the miss table: freeing an entry on completion and filling one on allocation. The bench fills all eight entries, then drives a completion of one tag and an allocation of a new tag on the same edge. It then confirms through the stall path that the completed tag no longer starts runahead mode and the new tag does. That can only hold if the completion was applied before the allocation searched for a free slot.

// File: rtl/rh_pkg.sv
package rh_pkg;
  typedef enum logic {
    RH_NORMAL = 1'b0,
    RH_AHEAD  = 1'b1
  } rh_mode_e;

  localparam int RH_FRAC_SHIFT = 4;
endpackage

// File: rtl/rh_miss_table.sv
module rh_miss_table #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 6,
  parameter int TIMER_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_vld,
  input  logic [TAG_W-1:0]   alloc_tag,
  input  logic               done_vld,
  input  logic [TAG_W-1:0]   done_tag,
  input  logic [TAG_W-1:0]   look_tag,
  output logic               look_hit,
  output logic [TIMER_W-1:0] look_age
);
  localparam logic [TIMER_W-1:0] TMAX = {TIMER_W{1'b1}};

  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] vld_kept;
  logic [ENTRIES-1:0] grant;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [TIMER_W-1:0] tmr_q [ENTRIES];

  // completion is applied first, then the allocation sees the freed slot
  always_comb begin
    logic found;
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      vld_kept[i] = vld_q[i] && !(done_vld && tag_q[i] == done_tag);
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (alloc_vld && !vld_kept[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
        tmr_q[g] <= '0;
      end else if (grant[g]) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= alloc_tag;
        tmr_q[g] <= '0;
      end else begin
        vld_q[g] <= vld_kept[g];
        if (vld_q[g] && tmr_q[g] != TMAX) tmr_q[g] <= tmr_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    look_hit = 1'b0;
    look_age = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld_q[i] && tag_q[i] == look_tag) begin
        look_hit = 1'b1;
        look_age = tmr_q[i];
      end
    end
  end
endmodule

// File: rtl/rh_overlap_guard.sv
module rh_overlap_guard #(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_ahead,
  input  logic enter,
  input  logic leave,
  input  logic pretire,
  input  logic fetch,
  output logic allow
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] pr_q, fe_q, last_q;
  logic [CNT_W-1:0] pr_next;

  always_comb begin
    pr_next = pr_q;
    if (in_ahead && pretire && pr_q != CMAX) pr_next = pr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pr_q   <= '0;
      fe_q   <= '0;
      last_q <= '0;
    end else begin
      if (enter) pr_q <= '0;
      else       pr_q <= pr_next;

      if (leave) begin
        last_q <= pr_next;
        fe_q   <= '0;
      end else if (!in_ahead && fetch && fe_q != CMAX) begin
        fe_q <= fe_q + 1'b1;
      end
    end
  end

  assign allow = (fe_q >= last_q);
endmodule

// File: rtl/rh_inv_monitor.sv
module rh_inv_monitor #(
  parameter int CNT_W  = 8,
  parameter int MIN_LD = 4,
  parameter int FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              in_ahead,
  input  logic              load_vld,
  input  logic              load_inv,
  input  logic [FRAC_W-1:0] thresh,
  output logic              bail
);
  import rh_pkg::*;
  localparam int PW = CNT_W + FRAC_W + RH_FRAC_SHIFT;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] ld_q, inv_q;
  logic [PW-1:0]    lhs, rhs;

  // counting stops at saturation so the ratio stays meaningful
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ld_q  <= '0;
      inv_q <= '0;
    end else if (in_ahead && load_vld && ld_q != CMAX) begin
      ld_q <= ld_q + 1'b1;
      if (load_inv) inv_q <= inv_q + 1'b1;
    end
  end

  always_comb begin
    lhs = PW'(inv_q) << RH_FRAC_SHIFT;
    rhs = PW'(thresh) * PW'(ld_q);
  end

  assign bail = in_ahead && (ld_q >= CNT_W'(MIN_LD)) && (lhs > rhs);
endmodule

// File: rtl/rh_entry_ctrl.sv
module rh_entry_ctrl #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 6,
  parameter int TIMER_W = 10,
  parameter int CNT_W   = 12,
  parameter int LD_W    = 8,
  parameter int MIN_LD  = 4,
  parameter int FRAC_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_alloc_vld,
  input  logic [TAG_W-1:0]   miss_alloc_tag,
  input  logic               miss_done_vld,
  input  logic [TAG_W-1:0]   miss_done_tag,
  input  logic               stall_vld,
  input  logic [TAG_W-1:0]   stall_tag,
  input  logic               stall_no_ra,
  input  logic               pretire_vld,
  input  logic               fetch_vld,
  input  logic               load_vld,
  input  logic               load_inv,
  input  logic [TIMER_W-1:0] age_thresh,
  input  logic [FRAC_W-1:0]  inv_thresh,
  output logic               ra_active,
  output logic               ckpt_req,
  output logic               flush_req,
  output logic               restore_req
);
  import rh_pkg::*;

  rh_mode_e           mode_q;
  logic [TAG_W-1:0]   cause_q;
  logic               look_hit, allow, bail;
  logic [TIMER_W-1:0] look_age;
  logic               go, leave, in_ahead;

  assign in_ahead = (mode_q == RH_AHEAD);

  rh_miss_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .TIMER_W(TIMER_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .alloc_vld(miss_alloc_vld), .alloc_tag(miss_alloc_tag),
    .done_vld(miss_done_vld), .done_tag(miss_done_tag),
    .look_tag(stall_tag), .look_hit(look_hit), .look_age(look_age)
  );

  rh_overlap_guard #(.CNT_W(CNT_W)) u_ovl (
    .clk(clk), .rst_n(rst_n), .in_ahead(in_ahead), .enter(go), .leave(leave),
    .pretire(pretire_vld), .fetch(fetch_vld), .allow(allow)
  );

  rh_inv_monitor #(.CNT_W(LD_W), .MIN_LD(MIN_LD), .FRAC_W(FRAC_W)) u_inv (
    .clk(clk), .rst_n(rst_n), .clear(go), .in_ahead(in_ahead),
    .load_vld(load_vld), .load_inv(load_inv), .thresh(inv_thresh), .bail(bail)
  );

  always_comb begin
    go = !in_ahead && stall_vld && !stall_no_ra && look_hit && allow
         && (look_age <= age_thresh)
         && !(miss_done_vld && miss_done_tag == stall_tag);
    leave = in_ahead && ((miss_done_vld && miss_done_tag == cause_q) || bail);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= RH_NORMAL;
      cause_q     <= '0;
      ckpt_req    <= 1'b0;
      flush_req   <= 1'b0;
      restore_req <= 1'b0;
    end else begin
      ckpt_req    <= go;
      flush_req   <= leave;
      restore_req <= leave;
      if (go) begin
        mode_q  <= RH_AHEAD;
        cause_q <= stall_tag;
      end else if (leave) begin
        mode_q <= RH_NORMAL;
      end
    end
  end

  assign ra_active = in_ahead;
endmodule

// File: rtl/rh_entry_ctrl_chk.sv
module rh_entry_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic stall_vld,
  input logic stall_no_ra,
  input logic ra_active,
  input logic ckpt_req,
  input logic flush_req,
  input logic restore_req
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !ckpt_req && !flush_req && !restore_req && !ra_active); // R1
  AST_CKPT_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) $rose(ra_active) |-> ckpt_req); // R2
  AST_CKPT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ckpt_req |=> !ckpt_req); // R2
  AST_HINT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (!ra_active && stall_vld && stall_no_ra) |=> !ra_active); // R6
  AST_EXIT_PULSES: assert property (@(posedge clk) disable iff (!rst_n) $fell(ra_active) |-> flush_req && restore_req); // R7
  AST_FLUSH_ONLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n) flush_req |-> !ra_active && $past(ra_active)); // R7
endmodule

bind rh_entry_ctrl rh_entry_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stall_vld(stall_vld), .stall_no_ra(stall_no_ra),
  .ra_active(ra_active), .ckpt_req(ckpt_req), .flush_req(flush_req),
  .restore_req(restore_req)
);

// File: tb/rh_entry_ctrl_test.sv
module rh_entry_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       miss_alloc_vld = 0, miss_done_vld = 0, stall_vld = 0, stall_no_ra = 0;
  logic [5:0] miss_alloc_tag = 0, miss_done_tag = 0, stall_tag = 0;
  logic       pretire_vld = 0, fetch_vld = 0, load_vld = 0, load_inv = 0;
  logic [9:0] age_thresh = 10'd400;
  logic [4:0] inv_thresh = 5'd16;
  logic       ra_active, ckpt_req, flush_req, restore_req;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  rh_entry_ctrl uut (.*);

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic alloc(int t);
    miss_alloc_vld = 1; miss_alloc_tag = 6'(t); step(); miss_alloc_vld = 0;
  endtask

  task automatic done(int t);
    miss_done_vld = 1; miss_done_tag = 6'(t); step(); miss_done_vld = 0;
  endtask

  task automatic stall(int t, bit hint);
    stall_vld = 1; stall_tag = 6'(t); stall_no_ra = hint; step();
    stall_vld = 0; stall_no_ra = 0;
  endtask

  task automatic t_reset;
    chk(!ra_active && !ckpt_req && !flush_req && !restore_req, "R1 reset", ra_active, 0);
  endtask

  task automatic t_basic;
    alloc(3);
    stall_vld = 1; stall_tag = 6'd3; step();
    chk(ra_active, "R2 entry", ra_active, 1);
    chk(ckpt_req, "R2 ckpt pulse", ckpt_req, 1);
    step();
    chk(!ckpt_req && ra_active, "R2 ckpt single cycle", ckpt_req, 0);
    stall_vld = 0;
    done(9);
    chk(ra_active && !flush_req, "R7 other tag no exit", ra_active, 1);
    done(3);
    chk(!ra_active && flush_req && restore_req, "R7 exit pulses", {flush_req, restore_req}, 3);
    step();
    chk(!flush_req && !restore_req, "R7 pulse single cycle", flush_req, 0);
  endtask

  task automatic t_unknown;
    stall(7, 0);
    chk(!ra_active && !ckpt_req, "R3 unknown tag", ra_active, 0);
  endtask

  task automatic t_hint;
    alloc(4);
    stall(4, 1);
    chk(!ra_active && !ckpt_req, "R6 hint blocks", ra_active, 0);
    stall(4, 0);
    chk(ra_active, "R6 same miss enters without hint", ra_active, 1);
    done(4); step();
  endtask

  task automatic t_age;
    age_thresh = 10'd20;
    alloc(5); step(40);
    stall(5, 0);
    chk(!ra_active, "R4 old miss suppressed", ra_active, 0);
    alloc(6); step(5);
    stall(6, 0);
    chk(ra_active, "R4 young miss enters", ra_active, 1);
    done(6); done(5); step();
    age_thresh = 10'd400;
  endtask

  task automatic t_overlap;
    alloc(8);
    stall(8, 0);
    chk(ra_active, "R5 first period", ra_active, 1);
    pretire_vld = 1; step(5); pretire_vld = 0;
    done(8);
    chk(!ra_active, "R5 first period ended", ra_active, 0);
    alloc(9);
    fetch_vld = 1; step(3); fetch_vld = 0;
    stall(9, 0);
    chk(!ra_active, "R5 overlap suppressed (3<5)", ra_active, 0);
    fetch_vld = 1; step(2); fetch_vld = 0;
    stall(9, 0);
    chk(ra_active, "R5 enters when fetched reaches 5", ra_active, 1);
    done(9); step();
  endtask

  task automatic t_inv;
    inv_thresh = 5'd8;
    alloc(11);
    stall(11, 0);
    chk(ra_active, "R8 period started", ra_active, 1);
    load_vld = 1; load_inv = 0; step(4); load_vld = 0;
    step(2);
    chk(ra_active, "R8 clean loads keep mode", ra_active, 1);
    load_vld = 1; load_inv = 1; step(8); load_vld = 0; load_inv = 0;
    step();
    chk(!ra_active, "R8 invalid share exit", ra_active, 0);
    done(11); step();
    inv_thresh = 5'd16;
  endtask

  task automatic t_full;
    for (int t = 16; t < 24; t++) alloc(t);
    miss_done_vld = 1; miss_done_tag = 6'd16;
    miss_alloc_vld = 1; miss_alloc_tag = 6'd30;
    step();
    miss_done_vld = 0; miss_alloc_vld = 0;
    stall(16, 0);
    chk(!ra_active, "R9 completed tag gone", ra_active, 0);
    stall(30, 0);
    chk(ra_active, "R9 new tag taken by full table", ra_active, 1);
    done(30);
    chk(!ra_active && flush_req, "R9 exit on new tag", ra_active, 0);
    for (int t = 17; t < 24; t++) done(t);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_unknown();
    t_hint();
    t_age();
    t_overlap();
    t_inv();
    t_full();
    step(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule